// File: doc/BRIEF.md
# Base-2 Strong Probable-Prime Tester

This unit decides whether an odd modulus N is a strong probable prime to the fixed base 2. A start pulse captures N. The unit then writes N-1 as 2^s times an odd m, removing one trailing zero per cycle. It raises 2 to the power m modulo N by left-to-right square-and-double over every bit of m. After that it squares the residue repeatedly and stops at the first step that settles the verdict. A one-cycle `done` pulse marks the end of a run. The verdict bit `is_prime` is then held until the next accepted start.

Every squaring goes through one iterative shift-and-add modular multiplier that handles one multiplier bit per cycle. Each step that multiplies by the base is a single-cycle modular doubling. An outer controller can assert `abort` to cancel a run, for example when another test has already rejected the candidate. The unit then returns to idle at once.

Top module: `mr2_tester`

## Requirements
- R1: `n_in` is sampled only on the cycle a start is accepted. Later changes to `n_in` have no effect on the running test.
- R2: `done` is high for exactly one cycle at the end of each run that completes.
- R3: For an odd prime N ≥ 5, the run ends with `is_prime` = 1.
- R4: For an odd composite N that is not a strong pseudoprime to base 2, the run ends with `is_prime` = 0. This holds when a squaring reaches 1 before N-1 (for example N = 341 or 561). It also holds when the squaring budget of s-1 steps runs out (for example N = 9, 15, 25).
- R5: A strong pseudoprime to base 2 (for example N = 2047 or 3277) is reported with `is_prime` = 1.
- R6: `is_prime` reads 0 while a run is in progress. It keeps its final value from the `done` pulse until the next accepted start or abort.
- R7: A start pulse that arrives while a run is in progress is ignored.
- R8: `abort` has priority over every state. One cycle after it is seen, `done` and `is_prime` are 0, the unit is idle, and no `done` is produced for the cancelled run.
- R9: After reset, `done` and `is_prime` are 0 and the unit is idle.
- R10: The smallest legal modulus (N = 5) and the largest odd moduli of the full width (for example 2^W-1 and 2^W-5) are handled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a test on `n_in` (honoured only when idle) |
| abort | input | 1 | Cancel any run and return to idle |
| n_in | input | W | Odd modulus under test, N ≥ 5 |
| done | output | 1 | One-cycle pulse when a verdict is ready |
| is_prime | output | 1 | 1 = strong probable prime to base 2, 0 = composite |

## Verification
The assertions assume that every modulus is odd and at least 5. Under that assumption N-1 is even and non-zero, so the trailing-zero strip ends with an odd m. The same assumption keeps every residue the multiplier returns below N. They also assume `start` and `abort` are driven synchronously. The stimulus uses only odd moduli from 5 up to 2^W-1. Control pulses are driven on the falling clock edge and last one cycle, so each request is seen by exactly one rising edge.

// File: rtl/mr2_pkg.sv
// Shared types for the base-2 strong probable-prime tester.
package mr2_pkg;

    // Controller states; order carries no meaning.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SPLIT_GO,
        ST_SPLIT_WAIT,
        ST_ESQ_GO,
        ST_ESQ_WAIT,
        ST_EXP_CHK,
        ST_LSQ_GO,
        ST_LSQ_WAIT,
        ST_LOOP_CHK
    } mr2_state_t;

endpackage

// File: rtl/mr2_split.sv
// Writes n-1 as 2^s * m with m odd, stripping one trailing zero per cycle.
// Assumes n is odd and at least 5, so n-1 is even and non-zero.
module mr2_split #(
    parameter int W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 go,
    input  logic [W-1:0]         n,
    output logic [W-1:0]         m,
    output logic [$clog2(W)-1:0] s,
    output logic                 done
);
    localparam int SW = $clog2(W);

    logic run;

    // Shift register that drops trailing zeros and counts them.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            m    <= '0;
            s    <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                m   <= n - W'(1);
                s   <= '0;
                run <= 1'b1;
            end else if (run) begin
                if (!m[0]) begin
                    m <= m >> 1;
                    s <= s + SW'(1);
                end else begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // The odd part is odd once the strip reports completion.
    assert_m_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (m[0] && s != '0));

endmodule

// File: rtl/mr2_modmul.sv
// Iterative modular multiplier: prod = a*b mod n, one bit of b per cycle,
// most significant bit first, W cycles per product.
// Assumes a < n and b < n, n odd; a and b are captured on go.
module mr2_modmul #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic [W-1:0] prod,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  areg, breg;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    dbl_w, dbl_r, sum_w, sum_r, n_x;

    // One step: double the accumulator, add a when the bit is set, reduce.
    always_comb begin
        n_x   = {1'b0, n};
        dbl_w = {prod, 1'b0};
        dbl_r = (dbl_w >= n_x) ? dbl_w - n_x : dbl_w;
        sum_w = breg[W-1] ? dbl_r + {1'b0, areg} : dbl_r;
        sum_r = (sum_w >= n_x) ? sum_w - n_x : sum_w;
    end

    // Accumulator, operand shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            prod <= '0;
            areg <= '0;
            breg <= '0;
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                prod <= '0;
                areg <= a;
                breg <= b;
                cnt  <= CW'(W);
                run  <= 1'b1;
            end else if (run) begin
                prod <= sum_r[W-1:0];
                breg <= breg << 1;
                cnt  <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Every finished product is a proper residue.
    assert_residue_reduced_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod < n));

endmodule

// File: rtl/mr2_tester.sv
// Base-2 strong probable-prime test of an odd modulus.
// Sequence: split n-1, compute 2^m mod n by square-and-double over all W bits
// of m, then up to s-1 squarings with early exit. abort wins over everything.
// Assumes n_in odd and >= 5; other inputs give an undefined verdict.
module mr2_tester #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] n_in,
    output logic         done,
    output logic         is_prime
);
    import mr2_pkg::*;

    localparam int SW = $clog2(W);

    mr2_state_t    state;
    logic [W-1:0]  nr, x, nm1, m_odd, prod;
    logic [W:0]    dbl_w, dbl_r;
    logic [SW-1:0] s_cnt, bit_idx, left;
    logic          split_go, split_done, mul_go, mul_done;

    assign nm1      = nr - W'(1);
    assign split_go = (state == ST_SPLIT_GO);
    assign mul_go   = (state == ST_ESQ_GO) || (state == ST_LSQ_GO);

    // Modular doubling of a fresh product: the multiply-by-base step.
    always_comb begin
        dbl_w = {prod, 1'b0};
        dbl_r = (dbl_w >= {1'b0, nr}) ? dbl_w - {1'b0, nr} : dbl_w;
    end

    mr2_split #(.W(W)) u_split (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (abort),
        .go   (split_go),
        .n    (nr),
        .m    (m_odd),
        .s    (s_cnt),
        .done (split_done)
    );

    mr2_modmul #(.W(W)) u_mul (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (abort),
        .go   (mul_go),
        .a    (x),
        .b    (x),
        .n    (nr),
        .prod (prod),
        .done (mul_done)
    );

    // Controller: exponentiation, decision ladder, verdict and abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state    <= ST_IDLE;
            nr       <= '0;
            x        <= '0;
            bit_idx  <= '0;
            left     <= '0;
            done     <= 1'b0;
            is_prime <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    nr       <= n_in;
                    is_prime <= 1'b0;
                    state    <= ST_SPLIT_GO;
                end
                ST_SPLIT_GO: state <= ST_SPLIT_WAIT;
                ST_SPLIT_WAIT: if (split_done) begin
                    x       <= W'(1);
                    bit_idx <= SW'(W - 1);
                    left    <= s_cnt - SW'(1);
                    state   <= ST_ESQ_GO;
                end
                ST_ESQ_GO: state <= ST_ESQ_WAIT;
                ST_ESQ_WAIT: if (mul_done) begin
                    x <= m_odd[bit_idx] ? dbl_r[W-1:0] : prod;
                    if (bit_idx == '0) state <= ST_EXP_CHK;
                    else begin
                        bit_idx <= bit_idx - SW'(1);
                        state   <= ST_ESQ_GO;
                    end
                end
                ST_EXP_CHK: begin
                    if (x == W'(1) || x == nm1) begin
                        done <= 1'b1; is_prime <= 1'b1; state <= ST_IDLE;
                    end else if (left == '0) begin
                        done <= 1'b1; state <= ST_IDLE;
                    end else state <= ST_LSQ_GO;
                end
                ST_LSQ_GO: state <= ST_LSQ_WAIT;
                ST_LSQ_WAIT: if (mul_done) begin
                    x     <= prod;
                    left  <= left - SW'(1);
                    state <= ST_LOOP_CHK;
                end
                ST_LOOP_CHK: begin
                    if (x == nm1) begin
                        done <= 1'b1; is_prime <= 1'b1; state <= ST_IDLE;
                    end else if (x == W'(1) || left == '0) begin
                        done <= 1'b1; state <= ST_IDLE;
                    end else state <= ST_LSQ_GO;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // done never lasts two cycles.
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // abort clears the outputs and reaches idle in one cycle.
    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!done && !is_prime && state == ST_IDLE));

    // An accepted start clears the held verdict.
    assert_start_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && state == ST_IDLE) |=> !is_prime);

    // The verdict changes only with done, a start or an abort.
    assert_verdict_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !abort) |=> (done || $stable(is_prime)));

    // The latched modulus stays put while a run is in progress.
    assert_modulus_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !abort) |=> $stable(nr));

endmodule

// File: tb/mr2_tester_tb.sv
`timescale 1ns/1ps
module mr2_tester_tb;
    localparam int W     = 32;
    localparam int LIMIT = 5000;
    localparam int NV    = 17;

    // {expected verdict, modulus}
    localparam logic [W:0] VEC [NV] = '{
        {1'b1, 32'd5},          {1'b1, 32'd7},          {1'b0, 32'd9},
        {1'b1, 32'd13},         {1'b0, 32'd15},         {1'b1, 32'd17},
        {1'b0, 32'd25},         {1'b1, 32'd97},         {1'b0, 32'd341},
        {1'b0, 32'd561},        {1'b0, 32'd1105},       {1'b1, 32'd2047},
        {1'b1, 32'd3277},       {1'b1, 32'd65537},      {1'b1, 32'd2147483647},
        {1'b1, 32'd4294967291}, {1'b0, 32'd4294967295}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         abort = 1'b0;
    logic [W-1:0] n_in = '0;
    logic         done, is_prime;
    int           checks = 0;
    int           failures = 0;

    always #2.5 clk = ~clk;

    mr2_tester #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .n_in(n_in), .done(done), .is_prime(is_prime)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [W-1:0] n);
        @(negedge clk); n_in = n; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Wait for done; returns the cycle count (LIMIT on timeout).
    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk); cyc++;
        end
    endtask

    task automatic run_one(input logic [W-1:0] n, input logic exp, input string req);
        int cyc;
        pulse_start(n);
        check(is_prime == 1'b0, "R6", "verdict cleared while running", is_prime, 0);
        wait_done(cyc);
        check(cyc < LIMIT, req, $sformatf("done seen for N=%0d", n), cyc, LIMIT);
        check(is_prime == exp, req, $sformatf("verdict for N=%0d", n), is_prime, exp);
        @(negedge clk);
        check(done == 1'b0, "R2", "done is one cycle", done, 0);
        repeat (5) @(negedge clk);
        check(is_prime == exp, "R6", "verdict held after done", is_prime, exp);
    endtask

    initial begin
        #(5.0 * 190000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R9", "done after reset", done, 0);
        check(is_prime == 1'b0, "R9", "verdict after reset", is_prime, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R3 primes, R4 composites, R5 pseudoprimes, R10 edges.
        for (int i = 0; i < NV; i++) begin
            string req;
            if (VEC[i][W-1:0] == 32'd2047 || VEC[i][W-1:0] == 32'd3277) req = "R5";
            else if (VEC[i][W-1:0] == 32'd5 || VEC[i][W-1:0] >= 32'd4294967291) req = "R10";
            else if (VEC[i][W]) req = "R3";
            else req = "R4";
            run_one(VEC[i][W-1:0], VEC[i][W], req);
        end

        // R1 and R7: new modulus and a second start mid-run are ignored.
        pulse_start(32'd341);
        repeat (100) @(negedge clk);
        n_in = 32'd65537; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_done(cyc);
        check(cyc < LIMIT, "R7", "done after ignored start", cyc, LIMIT);
        check(is_prime == 1'b0, "R1", "verdict of first modulus 341", is_prime, 0);

        // R8: abort mid-run, no done follows, unit accepts a fresh start.
        pulse_start(32'd4294967291);
        repeat (200) @(negedge clk);
        abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check(done == 1'b0 && is_prime == 1'b0, "R8", "outputs after abort",
              {done, is_prime}, 0);
        wait_done(cyc);
        check(cyc == LIMIT, "R8", "no done for cancelled run", cyc, LIMIT);
        run_one(32'd97, 1'b1, "R8");

        // R8: abort clears a held verdict.
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        check(is_prime == 1'b0, "R8", "held verdict cleared by abort", is_prime, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule